// File: doc/BRIEF.md
# Max-Log Soft-Output Bit Reliability Accumulator

This block sits at the back end of a soft-output MIMO tree-search detector. One detection vector carries NANT·BPS bits, which is 24 bits for four transmit antennas with 64-QAM. While the search for that vector runs, the search engine hands over each leaf it reaches as one candidate. A candidate is an unsigned path metric plus a label that holds one hard bit for each bit position. The block accepts at most one candidate per cycle through a valid/ready handshake.

For every bit position the block keeps two running minima: the smallest metric among candidates whose bit is +1, and the smallest among those whose bit is −1. One of the two is the metric of the detection hypothesis. The other is the metric of that bit's best counter-hypothesis. Alongside these, the block tracks the overall best hypothesis, meaning its metric and its label. A finish strobe closes the vector. The block then forms each bit's max-log L-value as a saturated difference of its two minima, packs all of them into one output word, and presents that word together with the best hypothesis. It then starts the next vector from empty state. Scaling by the noise variance is left to downstream logic.

Top module: `llr_maxlog_acc`

## Requirements
- R1: `cand_ready` is high in every cycle except one in which `finish` is high. A candidate is taken only in a cycle with `cand_valid` and `cand_ready` both high. A candidate offered during a finish cycle is not taken into any vector.
- R2: Label bit i equal to 1 stands for the value +1 and equal to 0 stands for −1. For each bit position i the block keeps the smallest metric among accepted candidates of the current vector with that bit at +1, and separately the smallest with that bit at −1.
- R3: When both values of bit i were seen, its L-value equals (minimum for −1) − (minimum for +1), clamped to the signed range −128..127. The result is placed in `llr_word[8i+7:8i]` in two's complement.
- R4: If only +1 was seen for bit i, its L-value is +127. If only −1 was seen, it is −128. If no candidate arrived in the vector, it is 0.
- R5: A finish strobe on one clock edge makes `llr_valid` high for exactly the following cycle, with the new `llr_word`, `best_metric` and `best_label`. These outputs keep their values until the next finish.
- R6: Every finish starts a new vector. All minima return to the maximum metric 255 with no bit value seen, and the best-hypothesis tracker returns to metric 255 with label 0. Candidates accepted before the finish edge count only toward the vector that finish closes.
- R7: `best_metric` and `best_label` give the smallest accepted metric of the vector and the label that came with it. On equal metrics the candidate that arrived first is kept. An empty vector reports 255 and label 0.
- R8: While reset is asserted and after it is released, `llr_valid` is 0 and `llr_word`, `best_metric` and `best_label` are 0, until the first finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_valid | input | 1 | Candidate present on `cand_metric`/`cand_label` |
| cand_ready | output | 1 | Block can take a candidate this cycle |
| cand_metric | input | 8 | Unsigned leaf metric of the candidate |
| cand_label | input | 24 | Hard bits of the candidate, 1 = +1 |
| finish | input | 1 | Closes the current vector |
| llr_valid | output | 1 | One-cycle pulse after a finish |
| llr_word | output | 192 | 24 signed 8-bit L-values, bit i at [8i+7:8i] |
| best_metric | output | 8 | Metric of the best hypothesis of the closed vector |
| best_label | output | 24 | Label of the best hypothesis of the closed vector |

## Verification
The assertions assume that `finish` and `cand_valid` are known, 0 or 1, at every sampling edge after reset. They also assume that a vector's candidates are valid only in cycles where the handshake completes. The bench drives every input on the falling edge from a defined idle state and releases reset with all strobes low, so both assumptions hold. It offers a candidate during a finish cycle only on purpose, to show that the candidate is refused. Metrics in the random vectors are drawn from a narrow range so that equal metrics and ties for the best hypothesis occur often.

// File: rtl/llr_pkg.sv
package llr_pkg;

  // Limit an integer to the closed range [lo, hi].
  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/llr_bit_slot.sv
module llr_bit_slot #(
  parameter int MW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          clr,
  input  logic          bit_is_one,
  input  logic [MW-1:0] metric,
  output logic [LW-1:0] llr_out
);
  import llr_pkg::*;

  localparam int MMAX = (1 << MW) - 1;
  localparam int LMAX = (1 << (LW - 1)) - 1;
  localparam int LMIN = -(1 << (LW - 1));

  logic [MW-1:0] min_neg, min_pos;
  logic          seen_neg, seen_pos;

  // internal events, named for the assertions
  logic hit_neg, hit_pos, lower_neg, lower_pos;
  assign hit_neg   = take && !bit_is_one;
  assign hit_pos   = take &&  bit_is_one;
  assign lower_neg = hit_neg && (metric < min_neg);
  assign lower_pos = hit_pos && (metric < min_pos);

  function automatic logic [LW-1:0] form_llr(input logic [MW-1:0] mn, input logic [MW-1:0] mp,
                                             input logic sn, input logic sp);
    int d;
    if (!sn && !sp)      d = 0;
    else if (!sn)        d = LMAX;
    else if (!sp)        d = LMIN;
    else                 d = clamp_int(int'(mn) - int'(mp), LMIN, LMAX);
    return LW'(d);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_neg  <= MW'(MMAX);
      min_pos  <= MW'(MMAX);
      seen_neg <= 1'b0;
      seen_pos <= 1'b0;
    end else if (clr) begin
      min_neg  <= MW'(MMAX);
      min_pos  <= MW'(MMAX);
      seen_neg <= 1'b0;
      seen_pos <= 1'b0;
    end else begin
      if (lower_neg) min_neg <= metric;
      if (lower_pos) min_pos <= metric;
      if (hit_neg)   seen_neg <= 1'b1;
      if (hit_pos)   seen_pos <= 1'b1;
    end
  end

  assign llr_out = form_llr(min_neg, min_pos, seen_neg, seen_pos);

  // R2: within a vector the minima never grow
  a_r2_min_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (min_neg <= $past(min_neg)) && (min_pos <= $past(min_pos)));

  // R6: a finish empties the slot
  a_r6_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!seen_neg && !seen_pos && min_neg == MW'(MMAX) && min_pos == MW'(MMAX)));

  // R2: a lower metric on the matching side is kept
  a_r2_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_pos && !clr) |=> (min_pos == $past(metric)) && seen_pos);

endmodule

// File: rtl/llr_best_track.sv
module llr_best_track #(
  parameter int MW = 8,
  parameter int NB = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          clr,
  input  logic [MW-1:0] metric,
  input  logic [NB-1:0] label,
  output logic [MW-1:0] cur_metric,
  output logic [NB-1:0] cur_label
);
  localparam int MMAX = (1 << MW) - 1;

  // strict comparison: an equal metric leaves the earlier candidate in place
  logic improve;
  assign improve = take && (metric < cur_metric);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_metric <= MW'(MMAX);
      cur_label  <= '0;
    end else if (clr) begin
      cur_metric <= MW'(MMAX);
      cur_label  <= '0;
    end else if (improve) begin
      cur_metric <= metric;
      cur_label  <= label;
    end
  end

  // R7: a strictly better candidate replaces the stored hypothesis
  a_r7_best_takes_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (improve && !clr) |=> (cur_metric == $past(metric)) && (cur_label == $past(label)));

  // R7: an equal or worse candidate leaves the hypothesis untouched
  a_r7_tie_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && metric >= cur_metric) |=> $stable(cur_metric) && $stable(cur_label));

endmodule

// File: rtl/llr_maxlog_acc.sv
module llr_maxlog_acc #(
  parameter int NANT = 4,
  parameter int BPS  = 6,
  parameter int MW   = 8,
  parameter int LW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cand_valid,
  output logic                     cand_ready,
  input  logic [MW-1:0]            cand_metric,
  input  logic [NANT*BPS-1:0]      cand_label,
  input  logic                     finish,
  output logic                     llr_valid,
  output logic [NANT*BPS*LW-1:0]   llr_word,
  output logic [MW-1:0]            best_metric,
  output logic [NANT*BPS-1:0]      best_label
);
  localparam int NB = NANT * BPS;

  logic take;
  assign cand_ready = !finish;
  assign take       = cand_valid && cand_ready;

  logic [NB*LW-1:0] llr_now;
  logic [MW-1:0]    cur_metric;
  logic [NB-1:0]    cur_label;

  for (genvar i = 0; i < NB; i++) begin : g_slot
    llr_bit_slot #(.MW(MW), .LW(LW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .clr        (finish),
      .bit_is_one (cand_label[i]),
      .metric     (cand_metric),
      .llr_out    (llr_now[i*LW +: LW])
    );
  end

  llr_best_track #(.MW(MW), .NB(NB)) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .clr        (finish),
    .metric     (cand_metric),
    .label      (cand_label),
    .cur_metric (cur_metric),
    .cur_label  (cur_label)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llr_valid   <= 1'b0;
      llr_word    <= '0;
      best_metric <= '0;
      best_label  <= '0;
    end else begin
      llr_valid <= finish;
      if (finish) begin
        llr_word    <= llr_now;
        best_metric <= cur_metric;
        best_label  <= cur_label;
      end
    end
  end

  // R5: every finish is answered by a result in the next cycle
  a_r5_valid_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> llr_valid);

  // R5: no result appears without a finish
  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> !llr_valid);

  // R5: outside a finish the presented result is held
  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(llr_word) && $stable(best_metric) && $stable(best_label));

endmodule

// File: tb/tb_llr_maxlog_acc.sv
module tb_llr_maxlog_acc;
  localparam int NB = 24;
  localparam int LW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cand_valid = 1'b0;
  logic            cand_ready;
  logic [7:0]      cand_metric = '0;
  logic [NB-1:0]   cand_label = '0;
  logic            finish = 1'b0;
  logic            llr_valid;
  logic [NB*LW-1:0] llr_word;
  logic [7:0]      best_metric;
  logic [NB-1:0]   best_label;

  int total = 0;
  int bad = 0;

  // bench model of the open vector
  int            e_neg[NB];
  int            e_pos[NB];
  bit            s_neg[NB];
  bit            s_pos[NB];
  int            e_best;
  logic [NB-1:0] e_best_lbl;

  always #10 clk = ~clk;

  llr_maxlog_acc dut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_metric(cand_metric), .cand_label(cand_label), .finish(finish),
    .llr_valid(llr_valid), .llr_word(llr_word), .best_metric(best_metric),
    .best_label(best_label)
  );

  task automatic check(input string tag, input bit ok, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NB; i++) begin
      e_neg[i] = 255; e_pos[i] = 255; s_neg[i] = 0; s_pos[i] = 0;
    end
    e_best = 255;
    e_best_lbl = '0;
  endtask

  function automatic int expect_llr(input int i);
    int d;
    if (!s_neg[i] && !s_pos[i]) return 0;
    if (!s_neg[i]) return 127;
    if (!s_pos[i]) return -128;
    d = e_neg[i] - e_pos[i];
    if (d > 127) d = 127;
    if (d < -128) d = -128;
    return d;
  endfunction

  // one accepted candidate, driven on the falling edge
  task automatic send(input int m, input logic [NB-1:0] lbl);
    @(negedge clk);
    cand_valid = 1'b1; cand_metric = 8'(m); cand_label = lbl;
    @(negedge clk);
    cand_valid = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (lbl[i]) begin s_pos[i] = 1; if (m < e_pos[i]) e_pos[i] = m; end
      else        begin s_neg[i] = 1; if (m < e_neg[i]) e_neg[i] = m; end
    end
    if (m < e_best) begin e_best = m; e_best_lbl = lbl; end
  endtask

  // close the vector and compare the result against the model
  task automatic close_and_check(input string tag);
    int bad_bit;
    int got;
    int exp_v;
    @(negedge clk);
    finish = 1'b1;
    @(negedge clk);
    finish = 1'b0;
    check("R5", llr_valid === 1'b1, $sformatf("%s valid act=%b exp=1", tag, llr_valid));
    bad_bit = -1; got = 0; exp_v = 0;
    for (int i = 0; i < NB; i++) begin
      if (bad_bit < 0 && int'($signed(llr_word[i*LW +: LW])) != expect_llr(i)) begin
        bad_bit = i; got = int'($signed(llr_word[i*LW +: LW])); exp_v = expect_llr(i);
      end
    end
    check(tag, bad_bit < 0, $sformatf("L-value bit %0d act=%0d exp=%0d", bad_bit, got, exp_v));
    check("R7", best_metric == 8'(e_best) && best_label == e_best_lbl,
          $sformatf("%s best act=%0d/%h exp=%0d/%h", tag, best_metric, best_label, e_best, e_best_lbl));
    model_clear();
    @(negedge clk);
    check("R5", llr_valid === 1'b0, $sformatf("%s pulse length act=%b exp=0", tag, llr_valid));
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NB*LW-1:0] held;
    model_clear();
    repeat (3) @(negedge clk);
    check("R8", llr_valid === 1'b0 && llr_word === '0 && best_metric === '0,
          $sformatf("in reset act=%b/%h exp=0/0", llr_valid, llr_word));
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", llr_valid === 1'b0 && llr_word === '0 && best_label === '0,
          $sformatf("after reset act=%b/%h exp=0/0", llr_valid, llr_word));
    check("R1", cand_ready === 1'b1, $sformatf("ready idle act=%b exp=1", cand_ready));

    // R4/R7: empty vector gives zeros and a 255 best metric
    close_and_check("R4_empty");

    // R4: single candidate saturates every bit
    send(10, 24'hA5C30F);
    close_and_check("R4_single");

    // R3: full scale difference clamps both ways
    send(0, 24'h00FFFF);
    send(255, 24'hFF0000);
    close_and_check("R3_clamp");

    // R3: small differences pass through unclamped
    send(50, 24'h123456);
    send(60, ~24'h123456);
    send(55, 24'h123456);
    close_and_check("R3_small");

    // R7: equal metrics keep the first label
    send(40, 24'h000111);
    send(40, 24'h222000);
    send(41, 24'h333333);
    close_and_check("R7_tie");

    // R1: candidate offered with finish is refused and lost
    @(negedge clk);
    finish = 1'b1; cand_valid = 1'b1; cand_metric = 8'd0; cand_label = '1;
    #1;
    check("R1", cand_ready === 1'b0, $sformatf("ready in finish act=%b exp=0", cand_ready));
    @(negedge clk);
    finish = 1'b0; cand_valid = 1'b0;
    check("R1", llr_word === '0, $sformatf("closed empty vector act=%h exp=0", llr_word));
    close_and_check("R1_refused");

    // R5: word holds while a new vector fills
    send(7, 24'hFFFFFF);
    held = llr_word;
    send(3, 24'h000000);
    repeat (4) @(negedge clk);
    check("R5", llr_word === held && llr_valid === 1'b0,
          $sformatf("hold act=%h exp=%h", llr_word, held));
    close_and_check("R5_hold");

    // R6: after a busy vector, a single candidate again saturates
    send(200, 24'h0F0F0F);
    close_and_check("R6_restart");

    // R2/R3: random vectors with narrow metric range and gaps
    for (int v = 0; v < 300; v++) begin
      int n;
      n = int'($urandom_range(1, 24));
      for (int c = 0; c < n; c++) begin
        int m;
        if ($urandom_range(0, 3) == 0) m = int'($urandom_range(0, 255));
        else m = int'($urandom_range(20, 60));
        send(m, NB'($urandom()));
        if ($urandom_range(0, 2) == 0) @(negedge clk);
      end
      close_and_check("R2_random");
    end

    // R5: back-to-back finishes give back-to-back pulses
    @(negedge clk);
    finish = 1'b1;
    @(negedge clk);
    check("R5", llr_valid === 1'b1, $sformatf("first of pair act=%b exp=1", llr_valid));
    @(negedge clk);
    finish = 1'b0;
    check("R5", llr_valid === 1'b1 && llr_word === '0,
          $sformatf("second of pair act=%b/%h exp=1/0", llr_valid, llr_word));
    @(negedge clk);
    check("R5", llr_valid === 1'b0, $sformatf("after pair act=%b exp=0", llr_valid));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule